// File: doc/BRIEF.md
# Collision-Free Line Grouping Engine

This engine runs once, after a self-test has written one fault vector per cache line into a small memory. Each bit of a vector marks one faulty chunk, the chunk being the smallest unit that can be swapped out. The engine sorts the lines into groups. Inside a group, no two lines are faulty at the same chunk position. The first line placed in a group becomes its sacrificial (spare) line. Every later line in that group is a data line, and its faulty chunks are served from the matching slots of the spare line. In this way n+1 partly broken lines can stand in for n working ones.

Placement is greedy first-fit, taken in line index order. A line joins the lowest-numbered open group whose accumulated fault mask shares no bit with the line's vector. If no open group fits, the line opens a new group. For every line the engine writes one memory-map entry giving its group and its role. After the last line it writes one fault-map entry per group, naming which data line owns each chunk slot of the spare line. The run stops with a fail flag if a line has too many faulty chunks, or if the group budget runs out. Once a run has finished or failed, the engine stays idle until it is reset.

Top module: `line_group_engine`

## Requirements
- R1: After reset, done_o, fail_o, fv_rd_o, mm_we_o and fm_we_o are all low, and they stay low until start_i is seen.
- R2: Lines are placed in index order. Each line joins the lowest-numbered open group whose accumulated fault mask ANDed with the line's vector is zero. If no open group fits, the line opens the next group number.
- R3: No two lines that receive the same group have a faulty chunk at the same position.
- R4: Each line gets exactly one memory-map write, in line order. mm_sacr_o is 1 for the line that opened the group and 0 for every line that joined an existing group.
- R5: After all lines are placed, there is one fault-map write per opened group, in group order. Chunk c of fm_data_o sits at bits [c*OWN_W +: OWN_W]. It holds line index + 1 of the data line that is faulty at c, or 0 when that slot is unused.
- R6: If a line fits no open group and MAX_GROUPS groups are already open, fail_o rises and stays high. That line gets no map write, and the run never gives done_o.
- R7: A line with more than MAX_FAULTS faulty chunks sets fail_o in the same way, and that line gets no map write.
- R8: done_o is high for exactly one cycle. That cycle comes right after the last fault-map write.
- R9: After done_o or fail_o, start_i is ignored until reset: there are no reads and no map writes.
- R10: A read is requested by fv_rd_o with fv_addr_o. fv_data_i is taken in the following cycle, and there is exactly one read per placed line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| fv_rd_o | output | 1 | Fault-vector read request |
| fv_addr_o | output | LINE_W | Line index to read |
| fv_data_i | input | NUM_CHUNKS | Fault vector, valid one cycle after the request |
| mm_we_o | output | 1 | Memory-map write strobe |
| mm_line_o | output | LINE_W | Memory-map address (line) |
| mm_group_o | output | GRP_W | Group assigned to the line |
| mm_sacr_o | output | 1 | 1 = sacrificial line, 0 = data line |
| fm_we_o | output | 1 | Fault-map write strobe |
| fm_group_o | output | GRP_W | Fault-map address (group) |
| fm_data_o | output | NUM_CHUNKS*OWN_W | Per-chunk owner codes |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Sticky failure flag |

## Verification
The bench reads both maps off the write ports and compares them with greedy placement worked out from the requirements. A bad accumulated mask shows up in two ways. It can give a wrong group or role on the memory-map write of the very next line that probes that group. It can also give a wrong owner code in the fault-map entries written at the end. A wrong group count shows at the first open beyond it, as an early or missing fail_o. It also shows as the wrong number of fault-map writes before done_o.

// File: rtl/lge_pkg.sv
package lge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_PLACE,
    ST_FLUSH,
    ST_DONE,
    ST_HALT
  } lge_state_t;
endpackage

// File: rtl/lge_fault_limit.sv
module lge_fault_limit #(
  parameter int NUM_CHUNKS = 4,
  parameter int MAX_FAULTS = 2
) (
  input  logic [NUM_CHUNKS-1:0] vec_i,
  output logic                  over_o
);
  localparam int CW = $clog2(NUM_CHUNKS + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int c = 0; c < NUM_CHUNKS; c++) begin
      ones = ones + CW'(vec_i[c]);
    end
  end

  assign over_o = (32'(ones) > MAX_FAULTS);
endmodule

// File: rtl/lge_fit_select.sv
module lge_fit_select #(
  parameter int NUM_CHUNKS = 4,
  parameter int MAX_GROUPS = 4,
  parameter int GRP_W      = 2
) (
  input  logic [MAX_GROUPS-1:0]                 valid_i,
  input  logic [MAX_GROUPS-1:0][NUM_CHUNKS-1:0] masks_i,
  input  logic [NUM_CHUNKS-1:0]                 vec_i,
  output logic                                  hit_o,
  output logic [GRP_W-1:0]                      idx_o
);
  logic [MAX_GROUPS-1:0] fit;

  for (genvar g = 0; g < MAX_GROUPS; g++) begin : g_fit
    assign fit[g] = valid_i[g] && ((masks_i[g] & vec_i) == '0);
  end

  // lowest fitting group wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int g = MAX_GROUPS - 1; g >= 0; g--) begin
      if (fit[g]) begin
        hit_o = 1'b1;
        idx_o = GRP_W'(g);
      end
    end
  end
endmodule

// File: rtl/lge_group_table.sv
module lge_group_table #(
  parameter int NUM_CHUNKS = 4,
  parameter int MAX_GROUPS = 4,
  parameter int GRP_W      = 2,
  parameter int CNT_W      = 3,
  parameter int OWN_W      = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  clr_i,
  input  logic                                  open_i,
  input  logic                                  join_i,
  input  logic [GRP_W-1:0]                      grp_i,
  input  logic [NUM_CHUNKS-1:0]                 vec_i,
  input  logic [OWN_W-1:0]                      owner_code_i,
  input  logic [GRP_W-1:0]                      rd_grp_i,
  output logic [MAX_GROUPS-1:0]                 valid_o,
  output logic [MAX_GROUPS-1:0][NUM_CHUNKS-1:0] masks_o,
  output logic [CNT_W-1:0]                      cnt_o,
  output logic [NUM_CHUNKS*OWN_W-1:0]           rd_owner_o
);
  logic [MAX_GROUPS-1:0]                       valid_q, valid_d;
  logic [MAX_GROUPS-1:0][NUM_CHUNKS-1:0]       mask_q, mask_d;
  logic [MAX_GROUPS-1:0][NUM_CHUNKS*OWN_W-1:0] own_q, own_d;
  logic [CNT_W-1:0]                            cnt_q, cnt_d;
  logic [GRP_W-1:0]                            new_idx;

  assign new_idx = cnt_q[GRP_W-1:0];

  always_comb begin
    valid_d = valid_q;
    mask_d  = mask_q;
    own_d   = own_q;
    cnt_d   = cnt_q;
    if (clr_i) begin
      valid_d = '0;
      mask_d  = '0;
      own_d   = '0;
      cnt_d   = '0;
    end else if (open_i) begin
      valid_d[new_idx] = 1'b1;
      mask_d[new_idx]  = vec_i;
      own_d[new_idx]   = '0;
      cnt_d            = cnt_q + CNT_W'(1);
    end else if (join_i) begin
      mask_d[grp_i] = mask_q[grp_i] | vec_i;
      for (int c = 0; c < NUM_CHUNKS; c++) begin
        if (vec_i[c]) own_d[grp_i][c*OWN_W +: OWN_W] = owner_code_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      mask_q  <= '0;
      own_q   <= '0;
      cnt_q   <= '0;
    end else if (clr_i || open_i || join_i) begin
      valid_q <= valid_d;
      mask_q  <= mask_d;
      own_q   <= own_d;
      cnt_q   <= cnt_d;
    end
  end

  assign valid_o    = valid_q;
  assign masks_o    = mask_q;
  assign cnt_o      = cnt_q;
  assign rd_owner_o = own_q[rd_grp_i];

  // R3: a join only ever lands on an open group with no shared faulty chunk
  a_r3_join_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
    join_i |-> (valid_q[grp_i] && ((mask_q[grp_i] & vec_i) == '0)));

  // R6: a group is never opened past the budget
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    open_i |-> (32'(cnt_q) < MAX_GROUPS));
endmodule

// File: rtl/line_group_engine.sv
module line_group_engine
  import lge_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int NUM_CHUNKS = 4,
  parameter int MAX_GROUPS = 4,
  parameter int MAX_FAULTS = 2,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int GRP_W  = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1,
  localparam int OWN_W  = $clog2(NUM_LINES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  output logic                        fv_rd_o,
  output logic [LINE_W-1:0]           fv_addr_o,
  input  logic [NUM_CHUNKS-1:0]       fv_data_i,
  output logic                        mm_we_o,
  output logic [LINE_W-1:0]           mm_line_o,
  output logic [GRP_W-1:0]            mm_group_o,
  output logic                        mm_sacr_o,
  output logic                        fm_we_o,
  output logic [GRP_W-1:0]            fm_group_o,
  output logic [NUM_CHUNKS*OWN_W-1:0] fm_data_o,
  output logic                        done_o,
  output logic                        fail_o
);
  localparam int CNT_W = $clog2(MAX_GROUPS + 1);

  lge_state_t  state_q, state_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [GRP_W-1:0]  flush_q, flush_d;
  logic              fail_q, fail_d;

  logic                                  over;
  logic                                  hit;
  logic [GRP_W-1:0]                      hit_idx;
  logic [MAX_GROUPS-1:0]                 grp_valid;
  logic [MAX_GROUPS-1:0][NUM_CHUNKS-1:0] grp_masks;
  logic [CNT_W-1:0]                      grp_cnt;
  logic                                  can_open, placing, place_ok;
  logic                                  do_open, do_join, do_clr;

  lge_fault_limit #(
    .NUM_CHUNKS (NUM_CHUNKS),
    .MAX_FAULTS (MAX_FAULTS)
  ) u_limit (
    .vec_i  (fv_data_i),
    .over_o (over)
  );

  lge_fit_select #(
    .NUM_CHUNKS (NUM_CHUNKS),
    .MAX_GROUPS (MAX_GROUPS),
    .GRP_W      (GRP_W)
  ) u_select (
    .valid_i (grp_valid),
    .masks_i (grp_masks),
    .vec_i   (fv_data_i),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  lge_group_table #(
    .NUM_CHUNKS (NUM_CHUNKS),
    .MAX_GROUPS (MAX_GROUPS),
    .GRP_W      (GRP_W),
    .CNT_W      (CNT_W),
    .OWN_W      (OWN_W)
  ) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (do_clr),
    .open_i       (do_open),
    .join_i       (do_join),
    .grp_i        (hit_idx),
    .vec_i        (fv_data_i),
    .owner_code_i (OWN_W'(line_q) + OWN_W'(1)),
    .rd_grp_i     (flush_q),
    .valid_o      (grp_valid),
    .masks_o      (grp_masks),
    .cnt_o        (grp_cnt),
    .rd_owner_o   (fm_data_o)
  );

  assign can_open = (32'(grp_cnt) < MAX_GROUPS);
  assign placing  = (state_q == ST_PLACE);
  assign place_ok = placing && !over && (hit || can_open);
  assign do_join  = placing && !over && hit;
  assign do_open  = placing && !over && !hit && can_open;
  assign do_clr   = (state_q == ST_IDLE) && start_i;

  // next-state process
  always_comb begin
    state_d = state_q;
    line_d  = line_q;
    flush_d = flush_q;
    fail_d  = fail_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_READ;
          line_d  = '0;
          fail_d  = 1'b0;
        end
      end
      ST_READ: state_d = ST_PLACE;
      ST_PLACE: begin
        if (!place_ok) begin
          state_d = ST_HALT;
          fail_d  = 1'b1;
        end else if (line_q == LINE_W'(NUM_LINES - 1)) begin
          state_d = ST_FLUSH;
          flush_d = '0;
        end else begin
          state_d = ST_READ;
          line_d  = line_q + LINE_W'(1);
        end
      end
      ST_FLUSH: begin
        if (CNT_W'(flush_q) == grp_cnt - CNT_W'(1)) state_d = ST_DONE;
        else flush_d = flush_q + GRP_W'(1);
      end
      ST_DONE: state_d = ST_HALT;
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      flush_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      line_q  <= line_d;
      flush_q <= flush_d;
      fail_q  <= fail_d;
    end
  end

  assign fv_rd_o    = (state_q == ST_READ);
  assign fv_addr_o  = line_q;
  assign mm_we_o    = place_ok;
  assign mm_line_o  = line_q;
  assign mm_group_o = hit ? hit_idx : grp_cnt[GRP_W-1:0];
  assign mm_sacr_o  = !hit;
  assign fm_we_o    = (state_q == ST_FLUSH);
  assign fm_group_o = flush_q;
  assign done_o     = (state_q == ST_DONE);
  assign fail_o     = fail_q;

  // R7: a memory-map write never carries an over-limit fault vector
  a_r7_fault_limit: assert property (@(posedge clk) disable iff (!rst_n)
    mm_we_o |-> ($countones(fv_data_i) <= MAX_FAULTS));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: failure is sticky until reset
  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> fail_o);

  // R9: nothing moves after completion or failure
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |=> (!fv_rd_o && !mm_we_o && !fm_we_o));

  // R10: each read is followed by a placement cycle, not another read
  a_r10_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    fv_rd_o |=> !fv_rd_o);
endmodule

// File: tb/line_group_engine_tb_top.sv
module line_group_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int NC = 4;
  localparam int MG = 4;
  localparam int MF = 2;
  localparam int OW = 4;
  localparam int NCASES = 6;

  // bit 32 = expected fail, bits [i*4 +: 4] = fault vector of line i
  localparam logic [32:0] CASES [NCASES] = '{
    {1'b0, 32'h0000_0000},
    {1'b0, 32'h8421_8421},
    {1'b1, 32'h1111_1111},
    {1'b1, 32'h0000_7000},
    {1'b0, 32'h0960_A5C3},
    {1'b0, 32'h0000_1111}
  };

  logic clk, rst_n, start;
  logic fv_rd, mm_we, mm_sacr, fm_we, done, fail;
  logic [2:0] fv_addr, mm_line;
  logic [1:0] mm_group, fm_group;
  logic [NC-1:0] fv_data;
  logic [NC*OW-1:0] fm_data;

  line_group_engine #(.NUM_LINES(NL), .NUM_CHUNKS(NC), .MAX_GROUPS(MG), .MAX_FAULTS(MF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .fv_rd_o(fv_rd), .fv_addr_o(fv_addr), .fv_data_i(fv_data),
    .mm_we_o(mm_we), .mm_line_o(mm_line), .mm_group_o(mm_group), .mm_sacr_o(mm_sacr),
    .fm_we_o(fm_we), .fm_group_o(fm_group), .fm_data_o(fm_data),
    .done_o(done), .fail_o(fail)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [NC-1:0] mem [NL];
  always_ff @(posedge clk) if (fv_rd) fv_data <= mem[fv_addr];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // captured write traffic
  int mm_cnt, fm_cnt, done_cnt, rd_cnt, order_err;
  logic [1:0] got_grp [NL];
  logic got_sacr [NL];
  logic [NC*OW-1:0] got_fm [MG];

  always @(negedge clk) begin
    if (rst_n) begin
      if (fv_rd) rd_cnt++;
      if (mm_we) begin
        if (int'(mm_line) != mm_cnt) order_err++;
        got_grp[mm_line] = mm_group;
        got_sacr[mm_line] = mm_sacr;
        mm_cnt++;
      end
      if (fm_we) begin
        if (int'(fm_group) != fm_cnt) order_err++;
        got_fm[fm_group] = fm_data;
        fm_cnt++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected values from greedy first-fit placement
  int exp_grp [NL];
  bit exp_sacr [NL];
  logic [NC*OW-1:0] exp_fm [MG];
  int exp_cnt, exp_placed;
  bit exp_fail;

  task automatic ref_model(input logic [31:0] img);
    logic [NC-1:0] masks [MG];
    bit stop = 0;
    exp_cnt = 0; exp_placed = 0; exp_fail = 0;
    for (int g = 0; g < MG; g++) begin masks[g] = '0; exp_fm[g] = '0; end
    for (int i = 0; i < NL; i++) begin
      logic [NC-1:0] v;
      int sel;
      v = img[i*NC +: NC];
      if (stop) continue;
      if ($countones(v) > MF) begin exp_fail = 1; stop = 1; continue; end
      sel = -1;
      for (int g = MG - 1; g >= 0; g--)
        if (g < exp_cnt && (masks[g] & v) == '0) sel = g;
      if (sel >= 0) begin
        exp_grp[i] = sel; exp_sacr[i] = 0;
        masks[sel] |= v;
        for (int c = 0; c < NC; c++) if (v[c]) exp_fm[sel][c*OW +: OW] = OW'(i + 1);
      end else if (exp_cnt < MG) begin
        exp_grp[i] = exp_cnt; exp_sacr[i] = 1;
        masks[exp_cnt] = v;
        exp_cnt++;
      end else begin
        exp_fail = 1; stop = 1; continue;
      end
      exp_placed++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    mm_cnt = 0; fm_cnt = 0; done_cnt = 0; rd_cnt = 0; order_err = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_case(input logic [31:0] img, input bit want_fail, input int idx);
    for (int i = 0; i < NL; i++) mem[i] = img[i*NC +: NC];
    ref_model(img);
    do_reset();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 100 && !done && !fail; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    check($sformatf("R6/R7 case%0d fail flag", idx), fail == exp_fail && exp_fail == want_fail,
          int'(fail), int'(want_fail));
    check($sformatf("R4 case%0d map writes in line order", idx),
          mm_cnt == exp_placed && order_err == 0, mm_cnt, exp_placed);
    check($sformatf("R10 case%0d one read per placed line", idx),
          rd_cnt == exp_placed + (exp_fail ? 1 : 0), rd_cnt, exp_placed + (exp_fail ? 1 : 0));
    for (int i = 0; i < exp_placed; i++) begin
      check($sformatf("R2 case%0d line%0d group", idx, i), int'(got_grp[i]) == exp_grp[i],
            int'(got_grp[i]), exp_grp[i]);
      check($sformatf("R4 case%0d line%0d role", idx, i), got_sacr[i] == exp_sacr[i],
            int'(got_sacr[i]), int'(exp_sacr[i]));
    end
    // R3: independent collision check over what was written
    for (int a = 0; a < exp_placed; a++)
      for (int b = a + 1; b < exp_placed; b++)
        if (got_grp[a] == got_grp[b])
          check($sformatf("R3 case%0d lines %0d,%0d disjoint", idx, a, b),
                (mem[a] & mem[b]) == '0, int'(mem[a] & mem[b]), 0);
    if (exp_fail) begin
      check($sformatf("R6 case%0d no done on fail", idx), done_cnt == 0 && fm_cnt == 0,
            done_cnt, 0);
    end else begin
      check($sformatf("R5 case%0d fault-map write count", idx), fm_cnt == exp_cnt, fm_cnt, exp_cnt);
      for (int g = 0; g < exp_cnt; g++)
        check($sformatf("R5 case%0d group%0d owners", idx, g), got_fm[g] == exp_fm[g],
              int'(got_fm[g]), int'(exp_fm[g]));
      check($sformatf("R8 case%0d single done pulse", idx), done_cnt == 1, done_cnt, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: quiet after reset with no start
    do_reset();
    repeat (4) @(negedge clk);
    check("R1 outputs low after reset", !done && !fail && !fv_rd && !mm_we && !fm_we,
          int'({done, fail, fv_rd, mm_we, fm_we}), 0);
    check("R1 no traffic without start", mm_cnt == 0 && rd_cnt == 0, mm_cnt + rd_cnt, 0);

    for (int n = 0; n < NCASES; n++) run_case(CASES[n][31:0], CASES[n][32], n);

    // R8: done comes right after the last fault-map write (case 1: 2 groups)
    for (int i = 0; i < NL; i++) mem[i] = CASES[1][i*NC +: NC];
    do_reset();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 2*NL + 2; k++) @(negedge clk);
    check("R8 done in cycle after last fault-map write", done == 1'b1 && fm_cnt == 2,
          int'(done), 1);
    @(negedge clk);
    check("R8 done drops after one cycle", done == 1'b0, int'(done), 0);

    // R9: start ignored after done
    start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check("R9 no reads or writes after done", rd_cnt == NL && mm_cnt == NL && fm_cnt == 2,
          rd_cnt + mm_cnt, 2*NL);

    // R9: start ignored after fail
    for (int i = 0; i < NL; i++) mem[i] = CASES[3][i*NC +: NC];
    do_reset();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check("R9 no new run after fail", fail && mm_cnt == 3 && rd_cnt == 4, mm_cnt, 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule